// File: doc/BRIEF.md
# Speculative Read/Write Set Tracker

This block keeps the memory footprint of one core's hardware transaction. It pairs a small direct-mapped data store with a fully associative write buffer. The data store has one word per line and one read-set bit per line. A transactional load marks the line it touches as read. A transactional store leaves the data store untouched and parks its address and new value in the write buffer. A later transactional load to that address gets the parked value back. Accesses without the transactional tag read and write the data store directly and leave no footprint.

A snoop port carries read and write requests from other cores. A snooped write collides with the transaction when it hits a buffered address or a line marked as read. A snooped read collides only when it hits a buffered address. Three events discard the transaction: a collision, a store that needs a new buffer slot while all slots are taken, and an explicit abort. Discarding clears every read mark and empties the buffer, so the data store keeps the old values. A commit clears the read marks and then copies the buffer into the data store, one entry per cycle. While the copy runs, both the core port and the snoop port are held off. A single pulse reports the end of the copy.

Top module: `spec_set_tracker`

## Requirements
- R1: After reset every output pulse (rd_valid, conflict, commit_done, cap_abort) and busy are low, req_ready and snp_ready are high, and every data word reads as 0.
- R2: A transactional load (req_tx=1, req_write=0) marks its line as read. A later snooped write (snp_write=1) to that line raises conflict. A snooped read (snp_write=0) to that line does not.
- R3: A transactional store (req_tx=1, req_write=1) does not change the data store. A non-transactional load to the same address still returns the old value.
- R4: A transactional load to an address held in the write buffer returns the buffered value.
- R5: An accepted snoop of either kind that hits a buffered address raises conflict. conflict is a one-cycle pulse in the cycle after the snoop is accepted. The same clock edge clears all read marks and empties the buffer.
- R6: A commit accepted while idle clears all read marks and raises busy. It then writes one buffered entry per cycle into the data store. With n entries, busy stays high for n+1 cycles, and commit_done pulses for one cycle as busy falls.
- R7: An abort accepted while idle empties the buffer and clears all read marks. The data store keeps its old values, and a snooped write to a formerly buffered address no longer raises conflict.
- R8: The buffer holds WB_DEPTH entries. A transactional store to an address already buffered overwrites that entry in place, even when the buffer is full, and raises no cap_abort. A transactional store to a new address while the buffer is full pulses cap_abort in the next cycle and discards the transaction as in R7.
- R9: Non-transactional stores write the data store at once. Non-transactional loads read it without marking the line, so a snooped write to that line raises no conflict.
- R10: While busy, req_ready and snp_ready are low. Requests and snoops presented then are ignored and produce neither rd_valid nor conflict.
- R11: Load data appears on rd_data with rd_valid high in the cycle after the load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core access request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_tx | input | 1 | 1 = access belongs to the transaction |
| req_addr | input | ADDR_W | Core access address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Core access can be accepted |
| rd_valid | output | 1 | Load data valid (one cycle) |
| rd_data | output | DATA_W | Load data |
| snp_valid | input | 1 | Snoop request from another core |
| snp_write | input | 1 | 1 = snooped write, 0 = snooped read |
| snp_addr | input | ADDR_W | Snoop address |
| snp_ready | output | 1 | Snoop can be accepted |
| conflict | output | 1 | Snoop collided with the footprint (one-cycle pulse) |
| commit | input | 1 | Commit the transaction |
| abort | input | 1 | Discard the transaction |
| busy | output | 1 | Commit copy in progress |
| commit_done | output | 1 | Commit copy finished (one-cycle pulse) |
| cap_abort | output | 1 | Store found the buffer full (one-cycle pulse) |

## Verification
The bench builds the block with its defaults: ADDR_W=5, DATA_W=16 and WB_DEPTH=8. The 32-line store keeps the reset-to-zero contents easy to predict. The eight-slot buffer can be filled with a handful of stores, so a full-buffer overwrite and a capacity discard are both reachable in a short directed test. Commit latency is measured against the number of distinct buffered addresses. A snoop held across the copy window checks that snoops are stalled during the drain.

// File: rtl/tracker_pkg.sv
// Shared types for the speculative read/write set tracker.
// Assumes nothing beyond a synthesizable enum encoding.
package tracker_pkg;
    typedef enum logic {
        TRK_IDLE  = 1'b0,
        TRK_DRAIN = 1'b1
    } trk_state_e;
endpackage

// File: rtl/trk_cache.sv
// Direct-mapped data store, one word per line, covering the local address
// window, with one read-set mark per line.
// Assumes at most one data write per cycle and that a clear of all marks
// wins over a set on the same edge.
module trk_cache #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] sn_addr,
    output logic              sn_rbit,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic              clr_all
);
    localparam int LINES = 1 << ADDR_W;

    logic [DATA_W-1:0] mem   [LINES];
    logic [LINES-1:0]  rbits;

    // Combinational read of data and of the snooped line's mark.
    assign rd_data = mem[rd_addr];
    assign sn_rbit = rbits[sn_addr];

    // Data array: reset to zero, single write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read-set marks: bulk clear has priority over a single set.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) rbits <= '0;
        else if (set_en)       rbits[set_addr] <= 1'b1;
    end
endmodule

// File: rtl/trk_wbuf.sv
// Fully associative buffer of speculative stores.
// A write to a buffered address overwrites in place, otherwise it takes the
// lowest free slot. The caller never writes a new address while full, and
// never writes and pops on the same edge.
module trk_wbuf #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic [ADDR_W-1:0] sn_addr,
    output logic              sn_hit,
    output logic              full,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop_en,
    input  logic              clear,
    output logic              head_valid,
    output logic [ADDR_W-1:0] head_addr,
    output logic [DATA_W-1:0] head_data
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  vld;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  lk_match, sn_match;
    logic [IW-1:0]     lk_idx, free_idx, head_idx;

    // Per-slot address comparators for the core and snoop ports.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign lk_match[g] = vld[g] && (addr_q[g] == lk_addr);
        assign sn_match[g] = vld[g] && (addr_q[g] == sn_addr);
    end

    assign lk_hit     = |lk_match;
    assign sn_hit     = |sn_match;
    assign full       = &vld;
    assign head_valid = |vld;

    // Priority encoders: matching slot, lowest free slot, lowest used slot.
    always_comb begin
        lk_idx   = '0;
        free_idx = '0;
        head_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (lk_match[i]) lk_idx   = IW'(i);
            if (!vld[i])     free_idx = IW'(i);
            if (vld[i])      head_idx = IW'(i);
        end
    end

    assign lk_data   = data_q[lk_idx];
    assign head_addr = addr_q[head_idx];
    assign head_data = data_q[head_idx];

    // Slot valid bits: allocate, retire at the head, or clear all.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)          vld <= '0;
        else if (pop_en)              vld[head_idx] <= 1'b0;
        else if (wr_en && !lk_hit)    vld[free_idx] <= 1'b1;
    end

    // Slot contents: written in place on a hit, into a free slot otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else if (wr_en && !clear) begin
            if (lk_hit) begin
                data_q[lk_idx] <= wr_data;
            end else begin
                addr_q[free_idx] <= lk_addr;
                data_q[free_idx] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/trk_ctrl.sv
// Commit sequencer: leaves idle on an accepted commit, retires one buffer
// entry per cycle, and pulses done on the edge where it finds the buffer empty.
// Assumes commit_go is only raised while idle.
module trk_ctrl
    import tracker_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic commit_go,
    input  logic head_valid,
    output logic busy,
    output logic pop_en,
    output logic done
);
    trk_state_e state;

    assign busy   = (state == TRK_DRAIN);
    assign pop_en = busy && head_valid;

    // State register and end-of-copy pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TRK_IDLE;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                TRK_IDLE:  if (commit_go) state <= TRK_DRAIN;
                TRK_DRAIN: if (!head_valid) begin
                    state <= TRK_IDLE;
                    done  <= 1'b1;
                end
                default:   state <= TRK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spec_set_tracker.sv
// Top of the speculative read/write set tracker. Ties the data store, the
// store buffer and the commit sequencer together. It detects snoop
// collisions and capacity overflow and discards the footprint on them.
// Assumes a discard (abort, collision, capacity) outranks any same-cycle
// transactional effect or commit. Commits and aborts arriving while busy
// are ignored.
module spec_set_tracker #(
    parameter int ADDR_W   = 5,
    parameter int DATA_W   = 16,
    parameter int WB_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_tx,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_ready,
    output logic              conflict,
    input  logic              commit,
    input  logic              abort,
    output logic              busy,
    output logic              commit_done,
    output logic              cap_abort
);
    logic              ld_acc, st_acc, tx_st, snp_acc;
    logic              lk_hit, sn_hit, wb_full, sn_rbit;
    logic [DATA_W-1:0] lk_data, cache_rd;
    logic              head_valid, pop_en, commit_go;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic              cap_now, conf_now, discard;
    logic              c_wr_en;
    logic [ADDR_W-1:0] c_wr_addr;
    logic [DATA_W-1:0] c_wr_data;

    // Acceptance of core requests and snoops; both stall during the copy.
    assign req_ready = !busy;
    assign snp_ready = !busy;
    assign ld_acc    = req_valid && req_ready && !req_write;
    assign st_acc    = req_valid && req_ready && req_write;
    assign tx_st     = st_acc && req_tx;
    assign snp_acc   = snp_valid && snp_ready;

    // Discard causes and commit acceptance.
    assign cap_now   = tx_st && wb_full && !lk_hit;
    assign conf_now  = snp_acc && (sn_hit || (snp_write && sn_rbit));
    assign discard   = (abort && !busy) || conf_now || cap_now;
    assign commit_go = commit && !busy && !discard;

    // Data-store write port: buffer head while copying, plain stores otherwise.
    always_comb begin
        if (busy) begin
            c_wr_en   = pop_en;
            c_wr_addr = head_addr;
            c_wr_data = head_data;
        end else begin
            c_wr_en   = st_acc && !req_tx;
            c_wr_addr = req_addr;
            c_wr_data = req_wdata;
        end
    end

    trk_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cache (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (req_addr),
        .rd_data  (cache_rd),
        .sn_addr  (snp_addr),
        .sn_rbit  (sn_rbit),
        .wr_en    (c_wr_en),
        .wr_addr  (c_wr_addr),
        .wr_data  (c_wr_data),
        .set_en   (ld_acc && req_tx && !discard),
        .set_addr (req_addr),
        .clr_all  (discard || commit_go)
    );

    trk_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_addr    (req_addr),
        .lk_hit     (lk_hit),
        .lk_data    (lk_data),
        .sn_addr    (snp_addr),
        .sn_hit     (sn_hit),
        .full       (wb_full),
        .wr_en      (tx_st && !discard),
        .wr_data    (req_wdata),
        .pop_en     (pop_en),
        .clear      (discard),
        .head_valid (head_valid),
        .head_addr  (head_addr),
        .head_data  (head_data)
    );

    trk_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_go  (commit_go),
        .head_valid (head_valid),
        .busy       (busy),
        .pop_en     (pop_en),
        .done       (commit_done)
    );

    // Registered load response and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            conflict  <= 1'b0;
            cap_abort <= 1'b0;
        end else begin
            rd_valid  <= ld_acc;
            if (ld_acc) rd_data <= (req_tx && lk_hit) ? lk_data : cache_rd;
            conflict  <= conf_now;
            cap_abort <= cap_now;
        end
    end
endmodule

// File: rtl/trk_checker.sv
// Temporal checks on the tracker's ports, attached by bind.
// Assumes the synchronous active-low reset of the top module.
module trk_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_write,
    input logic req_tx,
    input logic snp_valid,
    input logic snp_ready,
    input logic rd_valid,
    input logic conflict,
    input logic commit,
    input logic busy,
    input logic commit_done,
    input logic cap_abort
);
    // R5
    conflict_after_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> $past(snp_valid && snp_ready));
    // R6
    done_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> ($past(busy) && !busy));
    // R6
    busy_from_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit));
    // R8
    cap_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_abort |-> $past(req_valid && req_write && req_tx));
    // R10
    no_load_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rd_valid);
    // R10
    no_conflict_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !conflict);
endmodule

bind spec_set_tracker trk_checker u_trk_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_tx      (req_tx),
    .snp_valid   (snp_valid),
    .snp_ready   (snp_ready),
    .rd_valid    (rd_valid),
    .conflict    (conflict),
    .commit      (commit),
    .busy        (busy),
    .commit_done (commit_done),
    .cap_abort   (cap_abort)
);

// File: tb/spec_set_tracker_test.sv
module spec_set_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;
    localparam int DW = 16;

    // Vector: {op, addr, data, expected, req}
    // op: 0 plain store, 1 tx store, 2 plain load, 3 tx load,
    //     4 snoop read, 5 snoop write, 6 commit (expected = cycles to done), 7 abort
    // stores and aborts expect cap_abort = 0, loads expect rd_data, snoops expect conflict
    localparam int NV = 26;
    localparam logic [55:0] VEC [NV] = '{
        {8'd0, 8'd3,  16'h1111, 16'h0000, 8'd9},  // R9 plain store
        {8'd2, 8'd3,  16'h0000, 16'h1111, 8'd9},  // R9 plain store visible
        {8'd1, 8'd3,  16'h2222, 16'h0000, 8'd3},  // R3 tx store
        {8'd2, 8'd3,  16'h0000, 16'h1111, 8'd3},  // R3 old value kept
        {8'd3, 8'd3,  16'h0000, 16'h2222, 8'd4},  // R4 forwarding
        {8'd4, 8'd3,  16'h0000, 16'h0001, 8'd5},  // R5 snoop read hits buffer
        {8'd2, 8'd3,  16'h0000, 16'h1111, 8'd5},  // R5 discarded
        {8'd5, 8'd3,  16'h0000, 16'h0000, 8'd5},  // R5 buffer emptied
        {8'd3, 8'd5,  16'h0000, 16'h0000, 8'd2},  // R2 tx load marks line
        {8'd4, 8'd5,  16'h0000, 16'h0000, 8'd2},  // R2 snoop read no conflict
        {8'd5, 8'd5,  16'h0000, 16'h0001, 8'd2},  // R2 snoop write conflict
        {8'd5, 8'd5,  16'h0000, 16'h0000, 8'd5},  // R5 marks cleared
        {8'd2, 8'd6,  16'h0000, 16'h0000, 8'd9},  // R9 plain load
        {8'd5, 8'd6,  16'h0000, 16'h0000, 8'd9},  // R9 no mark from plain load
        {8'd1, 8'd7,  16'h0707, 16'h0000, 8'd6},  // R6 tx store
        {8'd1, 8'd8,  16'h0808, 16'h0000, 8'd6},  // R6 tx store
        {8'd3, 8'd9,  16'h0000, 16'h0000, 8'd6},  // R6 tx load marks 9
        {8'd6, 8'd0,  16'h0000, 16'h0003, 8'd6},  // R6 commit of two entries
        {8'd2, 8'd7,  16'h0000, 16'h0707, 8'd6},  // R6 drained
        {8'd2, 8'd8,  16'h0000, 16'h0808, 8'd6},  // R6 drained
        {8'd5, 8'd9,  16'h0000, 16'h0000, 8'd6},  // R6 marks cleared
        {8'd1, 8'd10, 16'hAAAA, 16'h0000, 8'd7},  // R7 tx store
        {8'd7, 8'd0,  16'h0000, 16'h0000, 8'd7},  // R7 abort
        {8'd2, 8'd10, 16'h0000, 16'h0000, 8'd7},  // R7 old value
        {8'd5, 8'd10, 16'h0000, 16'h0000, 8'd7},  // R7 buffer emptied
        {8'd6, 8'd0,  16'h0000, 16'h0001, 8'd6}   // R6 commit of empty buffer
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_tx = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic snp_valid = 1'b0, snp_write = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic snp_ready, conflict;
    logic commit = 1'b0, abort = 1'b0;
    logic busy, commit_done, cap_abort;

    int checks = 0;
    int fails = 0;
    bit ended = 1'b0;

    spec_set_tracker #(.ADDR_W(AW), .DATA_W(DW), .WB_DEPTH(8)) uut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Apply one operation; returns the observed result.
    task automatic run_op(input int op, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output logic [31:0] got);
        @(negedge clk);
        case (op)
            0, 1: begin req_valid = 1; req_write = 1; req_tx = (op == 1); req_addr = a; req_wdata = d; end
            2, 3: begin req_valid = 1; req_write = 0; req_tx = (op == 3); req_addr = a; end
            4, 5: begin snp_valid = 1; snp_write = (op == 5); snp_addr = a; end
            6:    commit = 1;
            default: abort = 1;
        endcase
        @(posedge clk); #1;
        req_valid = 0; snp_valid = 0; commit = 0; abort = 0;
        case (op)
            0, 1, 7: got = {31'd0, cap_abort};
            2, 3:    got = rd_valid ? {16'd0, rd_data} : 32'hDEAD;
            4, 5:    got = {31'd0, conflict};
            default: begin
                int n = 0;
                while (!commit_done && n < 50) begin
                    @(posedge clk); #1;
                    n++;
                end
                got = n;
            end
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!ended) begin
            fails++; checks++;
            $display("FAIL watchdog: got timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1 ready", {req_ready, snp_ready}, 2'b11);
        check("R1 pulses", {rd_valid, conflict, commit_done, cap_abort, busy}, 5'b0);
        run_op(2, 5'd31, '0, got);
        check("R1 data zero", got, 0);
        run_op(2, 5'd0, '0, got);
        check("R11 load response timing", got, 0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            run_op(int'(VEC[i][55:48]), VEC[i][44:40], VEC[i][39:24], got);
            checks++;
            if (got !== {16'd0, VEC[i][23:8]}) begin
                fails++;
                $display("FAIL R%0d vec %0d: got %0h expected %0h",
                         VEC[i][7:0], i, got, VEC[i][23:8]);
            end
        end

        // R8 capacity: fill eight slots
        for (int i = 0; i < 8; i++) begin
            run_op(1, AW'(16 + i), DW'(16'h0100 + i), got);
            check("R8 fill no cap_abort", got, 0);
        end
        run_op(1, 5'd16, 16'hBEEF, got);
        check("R8 overwrite when full", got, 0);
        run_op(3, 5'd16, '0, got);
        check("R8 overwrite value", got, 32'hBEEF);
        run_op(1, 5'd24, 16'h0999, got);
        check("R8 cap_abort pulse", got, 1);
        @(posedge clk); #1;
        check("R8 cap_abort one cycle", {31'd0, cap_abort}, 0);
        run_op(2, 5'd16, '0, got);
        check("R8 discarded old value", got, 0);
        run_op(4, 5'd17, '0, got);
        check("R8 buffer emptied", got, 0);

        // R10 stall during drain, with in-place overwrite
        run_op(1, 5'd20, 16'h0001, got);
        run_op(1, 5'd20, 16'h0002, got);
        run_op(1, 5'd21, 16'h0003, got);
        @(negedge clk);
        commit = 1;
        @(posedge clk); #1;
        commit = 0;
        check("R10 busy after commit", {busy, req_ready, snp_ready}, 3'b100);
        snp_valid = 1; snp_write = 0; snp_addr = 5'd21;
        req_valid = 1; req_write = 0; req_tx = 1; req_addr = 5'd21;
        begin
            int n = 0;
            int bad = 0;
            while (!commit_done && n < 50) begin
                @(posedge clk); #1;
                n++;
                if (conflict || rd_valid) bad++;
            end
            snp_valid = 0; req_valid = 0;
            check("R10 snoop and load ignored", bad, 0);
            check("R6 two entries after overwrite", n, 3);
        end
        run_op(2, 5'd20, '0, got);
        check("R8 latest overwrite committed", got, 2);
        run_op(2, 5'd21, '0, got);
        check("R6 second entry committed", got, 3);

        ended = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule